// File: doc/BRIEF.md
# Serial Display Host Write Port

This block is the write-only serial entry point of a display controller. A host drives a serial clock, a serial data line, a data/command select and two chip selects (one active low, one active high). All of these pins are oversampled in the faster system clock domain through multi-flop synchronizers. Rising edges of the serial clock are found there, and on each one the data bit is shifted into a byte register, most significant bit first.

When the eighth bit of a byte arrives, the data/command select is sampled on that same edge. The completed byte then leaves the block as a one-cycle write strobe. The strobe carries the byte and a flag that says whether the byte is meant for the display RAM or for the command register. Deselecting the port clears the bit count, so a partial byte is dropped. Bytes may follow one another with no idle serial clocks between them. The serial clock must run no faster than one quarter of the system clock.

Top module: `disp_ser_wr`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `wr_vld_o` is 0.
- R2: The byte on `wr_byte_o` holds the eight sampled data bits, the first one received in bit 7 and the last one in bit 0.
- R3: `wr_ram_o` equals the level of `dc_sel_i` at the eighth rising serial clock edge of the byte (1 = display RAM, 0 = command register). Its level during the first seven edges has no effect.
- R4: Each completed byte produces exactly one strobe, and `wr_vld_o` is never high in two consecutive cycles.
- R5: If the port is deselected in the middle of a byte, the bits received so far are dropped. The next byte after reselection is built from eight fresh bits.
- R6: Serial clock edges are ignored unless `sel_n_i` is 0 and `sel_i` is 1 at the same time. With either select inactive, no strobe is produced.
- R7: Bytes sent back to back with no idle serial clocks are each delivered. The bit count wraps to zero after every eighth bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Host serial clock (asynchronous) |
| ser_dat_i | input | 1 | Host serial data |
| dc_sel_i | input | 1 | Data/command select: 1 = display RAM, 0 = command |
| sel_n_i | input | 1 | Active-low chip select |
| sel_i | input | 1 | Active-high chip select |
| wr_vld_o | output | 1 | One-cycle write strobe |
| wr_byte_o | output | BYTE_W | Assembled byte |
| wr_ram_o | output | 1 | 1 = display RAM write, 0 = command register write |

## Verification
The eighth-bit edge does two things in the same system cycle. It completes the byte and issues the strobe, and it also wraps the bit counter, so the first bit of the next byte is counted from zero. A sweep of all 256 byte values with no gaps between bytes provokes this on every byte. During the first seven bits of each byte the select line is driven to the opposite of its final value. Each captured strobe is compared with the swept value and the expected destination, and the strobe count must equal the number of bytes sent.

// File: rtl/disp_ser_pkg.sv
package disp_ser_pkg;
   // order of bits in the synchronized pin vector
   localparam int PIN_SCLK = 0;
   localparam int PIN_DAT  = 1;
   localparam int PIN_DC   = 2;
   localparam int PIN_SELN = 3;
   localparam int PIN_SEL  = 4;
   localparam int PIN_CNT  = 5;

   typedef enum logic {
      DEST_CMD = 1'b0,
      DEST_RAM = 1'b1
   } dest_e;
endpackage

// File: rtl/disp_ser_sync.sv
module disp_ser_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("disp_ser_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("disp_ser_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= d_i;
            end
         end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/disp_ser_edge.sv
module disp_ser_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic rise_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~prev_q;

   // a rise can never be reported twice in a row (supports R4)
   p_rise_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/disp_ser_shift.sv
module disp_ser_shift #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise_i,
   input  logic              dat_i,
   input  logic              dc_i,
   input  logic              act_i,
   output logic              wr_vld_o,
   output logic [BYTE_W-1:0] wr_byte_o,
   output logic              wr_ram_o
);
   import disp_ser_pkg::*;

   localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

   generate
      if (BYTE_W < 2) begin : g_bad_byte
         $error("disp_ser_shift: BYTE_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-2:0] part_q;
   logic [BYTE_W-1:0] next_byte;
   logic              take;
   logic              last_bit;
   dest_e             dest;

   assign take      = rise_i & act_i;
   assign last_bit  = (cnt_q == LAST);
   assign next_byte = {part_q, dat_i};
   assign dest      = dc_i ? DEST_RAM : DEST_CMD;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         part_q <= '0;
      end else if (!act_i) begin
         cnt_q  <= '0;
      end else if (take) begin
         part_q <= next_byte[BYTE_W-2:0];
         cnt_q  <= last_bit ? '0 : cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_vld_o  <= 1'b0;
         wr_byte_o <= '0;
         wr_ram_o  <= 1'b0;
      end else begin
         wr_vld_o <= take & last_bit;
         if (take & last_bit) begin
            wr_byte_o <= next_byte;
            wr_ram_o  <= (dest == DEST_RAM);
         end
      end
   end

   p_deselect_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !act_i |=> (cnt_q == '0));
   p_no_write_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !act_i |=> !wr_vld_o);
   p_dest_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_vld_o |-> (wr_ram_o == $past(dc_i)));
   p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (take && last_bit) |=> (cnt_q == '0 && wr_vld_o));
   p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_vld_o |=> !wr_vld_o);
endmodule

// File: rtl/disp_ser_wr.sv
module disp_ser_wr #(
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk_i,
   input  logic              ser_dat_i,
   input  logic              dc_sel_i,
   input  logic              sel_n_i,
   input  logic              sel_i,
   output logic              wr_vld_o,
   output logic [BYTE_W-1:0] wr_byte_o,
   output logic              wr_ram_o
);
   import disp_ser_pkg::*;

   logic [PIN_CNT-1:0] pins_raw;
   logic [PIN_CNT-1:0] pins_s;
   logic               sclk_rise;
   logic               active;

   always_comb begin
      pins_raw           = '0;
      pins_raw[PIN_SCLK] = ser_clk_i;
      pins_raw[PIN_DAT]  = ser_dat_i;
      pins_raw[PIN_DC]   = dc_sel_i;
      // reset value 0 on the sync flop means "selected"; invert so idle is safe
      pins_raw[PIN_SELN] = ~sel_n_i;
      pins_raw[PIN_SEL]  = sel_i;
   end

   disp_ser_sync #(.WIDTH(PIN_CNT), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pins_raw),
      .q_o   (pins_s)
   );

   assign active = pins_s[PIN_SELN] & pins_s[PIN_SEL];

   disp_ser_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (pins_s[PIN_SCLK]),
      .rise_o (sclk_rise)
   );

   disp_ser_shift #(.BYTE_W(BYTE_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise_i    (sclk_rise),
      .dat_i     (pins_s[PIN_DAT]),
      .dc_i      (pins_s[PIN_DC]),
      .act_i     (active),
      .wr_vld_o  (wr_vld_o),
      .wr_byte_o (wr_byte_o),
      .wr_ram_o  (wr_ram_o)
   );

   always_comb begin
      if (!rst_n) p_reset_quiet_r1: assert (!wr_vld_o);
   end
endmodule

// File: tb/disp_ser_wr_tb.sv
module disp_ser_wr_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_clk = 1'b0, ser_dat = 1'b0, dc_sel = 1'b0;
   logic       sel_n = 1'b1, sel = 1'b0;
   logic       wr_vld;
   logic [7:0] wr_byte;
   logic       wr_ram;

   int vectors = 0;
   int fails   = 0;
   int cap_n   = 0;
   int dbl     = 0;
   logic [7:0] cap_byte [0:511];
   logic       cap_ram  [0:511];
   logic       vld_prev = 1'b0;
   bit         done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   disp_ser_wr u_dut (
      .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
      .dc_sel_i(dc_sel), .sel_n_i(sel_n), .sel_i(sel),
      .wr_vld_o(wr_vld), .wr_byte_o(wr_byte), .wr_ram_o(wr_ram)
   );

   always @(negedge clk) begin
      if (wr_vld) begin
         if (cap_n < 512) begin
            cap_byte[cap_n] = wr_byte;
            cap_ram[cap_n]  = wr_ram;
         end
         cap_n++;
         if (vld_prev) dbl++;
      end
      vld_prev = wr_vld;
   end

   task automatic check(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // one serial bit: 4 system cycles low, 4 high
   task automatic send_bit(input logic b, input logic dc);
      @(negedge clk);
      ser_clk = 1'b0; ser_dat = b; dc_sel = dc;
      repeat (4) @(negedge clk);
      ser_clk = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] v, input logic dc);
      for (int i = 7; i >= 0; i--)
         send_bit(v[i], (i == 0) ? dc : ~dc);
   endtask

   task automatic idle(input int n);
      @(negedge clk); ser_clk = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin : stim
      int base;
      repeat (3) @(negedge clk);
      check("R1 reset", wr_vld, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", wr_vld, 0);

      // R2/R3/R7: full sweep, back to back, dc flipped until last bit
      sel_n = 1'b0; sel = 1'b1;
      idle(6);
      for (int v = 0; v < 256; v++)
         send_byte(v[7:0], (v % 3) == 0);
      idle(10);
      check("R7 byte count", cap_n, 256);
      for (int v = 0; v < 256; v++) begin
         if (v < cap_n) begin
            check("R2 byte", cap_byte[v], v);
            check("R3 dest", cap_ram[v], ((v % 3) == 0) ? 1 : 0);
         end
      end

      // R5: partial byte dropped on deselect
      base = cap_n;
      send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0);
      idle(2);
      sel_n = 1'b1;
      idle(8);
      sel_n = 1'b0;
      idle(8);
      send_byte(8'hA5, 1'b1);
      idle(10);
      check("R5 count", cap_n - base, 1);
      if (cap_n > base) begin
         check("R5 byte", cap_byte[base], 8'hA5);
         check("R5 dest", cap_ram[base], 1);
      end

      // R6: each select inactive alone blocks writes
      base = cap_n;
      sel = 1'b0;
      idle(8);
      send_byte(8'h3C, 1'b0);
      idle(10);
      check("R6 sel low", cap_n - base, 0);
      sel = 1'b1; sel_n = 1'b1;
      idle(8);
      send_byte(8'hC3, 1'b0);
      idle(10);
      check("R6 sel_n high", cap_n - base, 0);

      // after reselect, a full byte to the command register
      sel_n = 1'b0;
      idle(8);
      send_byte(8'h5A, 1'b0);
      idle(10);
      check("R6 reselect count", cap_n - base, 1);
      if (cap_n > base) begin
         check("R2 reselect byte", cap_byte[base], 8'h5A);
         check("R3 cmd dest", cap_ram[base], 0);
      end

      check("R4 single-cycle strobes", dbl, 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule